// File: doc/BRIEF.md
# Character LCD power-up initialisation sequencer

This block brings a character LCD controller out of its undefined power-on state and into 4-bit operation, then programs the display. It sits between a nibble bus engine and the user's traffic. After reset it keeps every request low for a long settle delay. It then sends the wake-up nibble 0x3 three times on the engine's raw-nibble port, which gives no busy-flag wait. A long delay follows the first of these and a short delay follows the second. The fourth nibble, 0x2, switches the controller to 4-bit mode.

Three full-byte commands follow on the engine's byte port, where the engine polls the busy flag: function set, display on, and clear. When the clear command has completed the block raises a ready flag and connects the user's byte requests straight to the engine. Until then, user requests are held off. A line count other than 1 or 2 leaves the block idle forever.

Parameters set the line count, the font, and the three delays in clock cycles. At a 250 MHz clock the default delays are 15 ms, 4.1 ms and 100 us. Every request follows the same handshake. The request stays high with a stable value until the engine returns a one-cycle done pulse.

Top module: `lcd_init_seq`

## Requirements
- R1: From reset until the first nibble request, nib_req_o, cmd_req_o and ready_o are low and nib_o reads 0. The first nibble request rises no earlier than PWR_WAIT_CYC cycles after reset release, and no later than PWR_WAIT_CYC+4 cycles after it.
- R2: The first raw nibble is 0x3. The second nibble request starts at least LONG_WAIT_CYC cycles after the first completes, and at most LONG_WAIT_CYC+4 cycles after it.
- R3: The second and third nibbles are 0x3. The third request starts at least SHORT_WAIT_CYC cycles after the second completes, and at most SHORT_WAIT_CYC+4 cycles after it.
- R4: The fourth nibble is 0x2. It is requested within 3 cycles of the third completing, and no byte command is requested before it completes. No nibble is requested once ready_o is high.
- R5: The first byte command is the function-set value: 0x20, plus 0x08 when LINES is 2, plus 0x04 when BIG_FONT is 1. It is sent with cmd_rs_o low.
- R6: Display-on 0x0C and then clear 0x01 follow, each with cmd_rs_o low. Each one starts only after the previous command has completed.
- R7: A request stays high, with its value stable, until its done pulse. For the byte port this applies while ready_o is low.
- R8: The nibble and byte ports are never requested in the same cycle.
- R9: ready_o rises in the cycle after the done pulse of the clear command. It stays high until reset.
- R10: While ready_o is low, user requests reach no output and usr_done_o stays low. Once ready_o is high, usr_req_i, usr_data_i and usr_rs_i drive the byte port in the same cycle, and cmd_done_i is returned on usr_done_o.
- R11: With LINES other than 1 or 2, no request is ever issued and ready_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_req_o | output | 1 | Raw-nibble request to the bus engine (no busy polling) |
| nib_o | output | 4 | Nibble value |
| nib_done_i | input | 1 | One-cycle completion pulse for a nibble |
| cmd_req_o | output | 1 | Byte request to the bus engine (busy-polled) |
| cmd_o | output | 8 | Byte value |
| cmd_rs_o | output | 1 | Register select: 0 command, 1 data |
| cmd_done_i | input | 1 | One-cycle completion pulse for a byte |
| usr_req_i | input | 1 | User byte request |
| usr_data_i | input | 8 | User byte value |
| usr_rs_i | input | 1 | User register select |
| usr_done_o | output | 1 | Completion pulse returned to the user |
| ready_o | output | 1 | Initialisation finished |

## Verification
A wrong sequencer state shows up at the ports as a wrong or missing value in the request stream. It can also show up as a stray value: a fifth nibble, a command issued out of turn, or user traffic passing early. The error is visible from the next handshake onward. A counter that loads or expires at the wrong time shows up as a gap between a done pulse and the next request that falls outside the window. The gap is measured from the log kept by the engine model. A ready flag that rises early, late or not at all shows up in the cycle after the clear command completes.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_NIB_A,
    ST_WAIT_L,
    ST_NIB_B,
    ST_WAIT_S,
    ST_NIB_C,
    ST_NIB_4B,
    ST_FSET,
    ST_DISP,
    ST_CLR,
    ST_READY,
    ST_HALT
  } seq_state_e;

  localparam logic [3:0] NIB_WAKE    = 4'h3;
  localparam logic [3:0] NIB_4BIT    = 4'h2;
  localparam logic [7:0] CMD_DISP_ON = 8'h0C;
  localparam logic [7:0] CMD_CLEAR   = 8'h01;

  function automatic logic lines_ok(input int lines);
    return (lines == 1) || (lines == 2);
  endfunction

  function automatic logic [7:0] fset_cmd(input int lines, input int big_font);
    logic [7:0] v;
    v = 8'h20;
    if (lines == 2) v = v | 8'h08;
    if (big_font != 0) v = v | 8'h04;
    return v;
  endfunction

endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int               CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= INIT;
    else if (ld_i)          cnt_q <= ld_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_init_fsm.sv
module lcd_init_fsm
  import lcd_init_pkg::*;
#(
  parameter int LINES     = 2,
  parameter int BIG_FONT  = 1,
  parameter int CNT_W     = 8,
  parameter int LONG_CYC  = 100,
  parameter int SHORT_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             nib_done_i,
  input  logic             cmd_done_i,
  output logic             ld_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             nib_req_o,
  output logic [3:0]       nib_o,
  output logic             cmd_req_o,
  output logic [7:0]       cmd_o,
  output logic             ready_o
);

  localparam logic             LEGAL   = lines_ok(LINES);
  localparam logic [7:0]       FSET    = fset_cmd(LINES, BIG_FONT);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LEGAL ? ST_PWR : ST_HALT;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    ld_o     = 1'b0;
    ld_val_o = '0;
    unique case (state_q)
      ST_PWR:    if (zero_i) state_d = ST_NIB_A;
      ST_NIB_A:  if (nib_done_i) begin
                   state_d  = ST_WAIT_L;
                   ld_o     = 1'b1;
                   ld_val_o = LONG_V;
                 end
      ST_WAIT_L: if (zero_i) state_d = ST_NIB_B;
      ST_NIB_B:  if (nib_done_i) begin
                   state_d  = ST_WAIT_S;
                   ld_o     = 1'b1;
                   ld_val_o = SHORT_V;
                 end
      ST_WAIT_S: if (zero_i) state_d = ST_NIB_C;
      ST_NIB_C:  if (nib_done_i) state_d = ST_NIB_4B;
      ST_NIB_4B: if (nib_done_i) state_d = ST_FSET;
      ST_FSET:   if (cmd_done_i) state_d = ST_DISP;
      ST_DISP:   if (cmd_done_i) state_d = ST_CLR;
      ST_CLR:    if (cmd_done_i) state_d = ST_READY;
      ST_READY:  state_d = ST_READY;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_comb begin
    nib_req_o = 1'b0;
    nib_o     = '0;
    cmd_req_o = 1'b0;
    cmd_o     = '0;
    unique case (state_q)
      ST_NIB_A, ST_NIB_B, ST_NIB_C: begin
        nib_req_o = 1'b1;
        nib_o     = NIB_WAKE;
      end
      ST_NIB_4B: begin
        nib_req_o = 1'b1;
        nib_o     = NIB_4BIT;
      end
      ST_FSET: begin
        cmd_req_o = 1'b1;
        cmd_o     = FSET;
      end
      ST_DISP: begin
        cmd_req_o = 1'b1;
        cmd_o     = CMD_DISP_ON;
      end
      ST_CLR: begin
        cmd_req_o = 1'b1;
        cmd_o     = CMD_CLEAR;
      end
      default: ;
    endcase
  end

  assign ready_o = (state_q == ST_READY);

endmodule

// File: rtl/lcd_init_mux.sv
module lcd_init_mux (
  input  logic       ready_i,
  input  logic       seq_req_i,
  input  logic [7:0] seq_cmd_i,
  input  logic       usr_req_i,
  input  logic [7:0] usr_data_i,
  input  logic       usr_rs_i,
  input  logic       cmd_done_i,
  output logic       cmd_req_o,
  output logic [7:0] cmd_o,
  output logic       cmd_rs_o,
  output logic       usr_done_o
);

  always_comb begin
    if (ready_i) begin
      cmd_req_o  = usr_req_i;
      cmd_o      = usr_data_i;
      cmd_rs_o   = usr_rs_i;
      usr_done_o = cmd_done_i;
    end else begin
      cmd_req_o  = seq_req_i;
      cmd_o      = seq_cmd_i;
      cmd_rs_o   = 1'b0;
      usr_done_o = 1'b0;
    end
  end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int LINES          = 2,
  parameter int BIG_FONT       = 1,
  parameter int PWR_WAIT_CYC   = 3750000,
  parameter int LONG_WAIT_CYC  = 1025000,
  parameter int SHORT_WAIT_CYC = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       nib_req_o,
  output logic [3:0] nib_o,
  input  logic       nib_done_i,
  output logic       cmd_req_o,
  output logic [7:0] cmd_o,
  output logic       cmd_rs_o,
  input  logic       cmd_done_i,
  input  logic       usr_req_i,
  input  logic [7:0] usr_data_i,
  input  logic       usr_rs_i,
  output logic       usr_done_o,
  output logic       ready_o
);

  localparam int MAX_A    = (PWR_WAIT_CYC > LONG_WAIT_CYC) ? PWR_WAIT_CYC : LONG_WAIT_CYC;
  localparam int MAX_WAIT = (MAX_A > SHORT_WAIT_CYC) ? MAX_A : SHORT_WAIT_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             zero;
  logic             seq_req;
  logic [7:0]       seq_cmd;

  lcd_init_timer #(
    .CNT_W (CNT_W),
    .INIT  (CNT_W'(PWR_WAIT_CYC))
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .zero_o   (zero)
  );

  lcd_init_fsm #(
    .LINES     (LINES),
    .BIG_FONT  (BIG_FONT),
    .CNT_W     (CNT_W),
    .LONG_CYC  (LONG_WAIT_CYC),
    .SHORT_CYC (SHORT_WAIT_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (zero),
    .nib_done_i (nib_done_i),
    .cmd_done_i (cmd_done_i),
    .ld_o       (ld),
    .ld_val_o   (ld_val),
    .nib_req_o  (nib_req_o),
    .nib_o      (nib_o),
    .cmd_req_o  (seq_req),
    .cmd_o      (seq_cmd),
    .ready_o    (ready_o)
  );

  lcd_init_mux u_mux (
    .ready_i    (ready_o),
    .seq_req_i  (seq_req),
    .seq_cmd_i  (seq_cmd),
    .usr_req_i  (usr_req_i),
    .usr_data_i (usr_data_i),
    .usr_rs_i   (usr_rs_i),
    .cmd_done_i (cmd_done_i),
    .cmd_req_o  (cmd_req_o),
    .cmd_o      (cmd_o),
    .cmd_rs_o   (cmd_rs_o),
    .usr_done_o (usr_done_o)
  );

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int LINES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nib_req_o,
  input logic [3:0] nib_o,
  input logic       nib_done_i,
  input logic       cmd_req_o,
  input logic [7:0] cmd_o,
  input logic       cmd_rs_o,
  input logic       cmd_done_i,
  input logic       usr_done_o,
  input logic       ready_o
);

  // R8
  no_dual_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nib_req_o && cmd_req_o));

  // R7
  nib_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_req_o && !nib_done_i) |=> (nib_req_o && $stable(nib_o)));

  // R7
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && cmd_req_o && !cmd_done_i) |=> (cmd_req_o && $stable(cmd_o)));

  // R9
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R9
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(cmd_done_i));

  // R10
  usr_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !usr_done_o);

  // R4
  no_nib_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !nib_req_o);

  // R5
  seq_cmd_rs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && cmd_req_o) |-> !cmd_rs_o);

  generate
    if (LINES != 1 && LINES != 2) begin : g_bad
      // R11
      bad_lines_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nib_req_o && !cmd_req_o && !ready_o);
    end
  endgenerate

endmodule

bind lcd_init_seq lcd_init_seq_chk #(.LINES(LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nib_req_o  (nib_req_o),
  .nib_o      (nib_o),
  .nib_done_i (nib_done_i),
  .cmd_req_o  (cmd_req_o),
  .cmd_o      (cmd_o),
  .cmd_rs_o   (cmd_rs_o),
  .cmd_done_i (cmd_done_i),
  .usr_done_o (usr_done_o),
  .ready_o    (ready_o)
);

// File: tb/test_lcd_init_seq.sv
module lcd_engine_model #(
  parameter int DLY = 2
) (
  input  logic       clk_i,
  input  logic       nib_req_i,
  input  logic [3:0] nib_i,
  output logic       nib_done_o,
  input  logic       cmd_req_i,
  input  logic [7:0] cmd_i,
  input  logic       cmd_rs_i,
  output logic       cmd_done_o
);
  int cyc = 0;
  int n = 0;
  int viol = 0;
  int wt_n = 0;
  int wt_c = 0;
  int st_n = 0;
  int st_c = 0;
  logic       live_n_q = 1'b0;
  logic       live_c_q = 1'b0;
  logic [3:0] nib_v = '0;
  logic [7:0] cmd_v = '0;
  logic [7:0] val_l [16];
  logic       kind_l[16];
  logic       rs_l  [16];
  int         st_l  [16];
  int         dn_l  [16];

  initial begin
    nib_done_o = 1'b0;
    cmd_done_o = 1'b0;
  end

  always @(posedge clk_i) begin
    logic live_n, live_c;
    live_n = nib_req_i && !nib_done_o;
    live_c = cmd_req_i && !cmd_done_o;
    cyc        <= cyc + 1;
    nib_done_o <= 1'b0;
    cmd_done_o <= 1'b0;
    live_n_q   <= live_n;
    live_c_q   <= live_c;
    nib_v      <= nib_i;
    cmd_v      <= cmd_i;
    if ((nib_req_i && cmd_req_i) ||
        (live_n && live_n_q && nib_i != nib_v) ||
        (live_c && live_c_q && cmd_i != cmd_v))
      viol <= viol + 1;
    if (live_n && !live_n_q) st_n <= cyc;
    if (live_c && !live_c_q) st_c <= cyc;
    if (live_n) begin
      if (wt_n == DLY) begin
        nib_done_o <= 1'b1;
        wt_n <= 0;
        if (n < 16) begin
          val_l[n] <= {4'h0, nib_i}; kind_l[n] <= 1'b0; rs_l[n] <= 1'b0;
          st_l[n] <= st_n; dn_l[n] <= cyc;
        end
        n <= n + 1;
      end else wt_n <= wt_n + 1;
    end
    if (live_c) begin
      if (wt_c == DLY) begin
        cmd_done_o <= 1'b1;
        wt_c <= 0;
        if (n < 16) begin
          val_l[n] <= cmd_i; kind_l[n] <= 1'b1; rs_l[n] <= cmd_rs_i;
          st_l[n] <= st_c; dn_l[n] <= cyc;
        end
        n <= n + 1;
      end else wt_c <= wt_c + 1;
    end
  end
endmodule

module test_lcd_init_seq;
  localparam int T_PWR = 300;
  localparam int T_LONG = 80;
  localparam int T_SHORT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int rel = 0;

  logic       nib_req, nib_done, cmd_req, cmd_rs, cmd_done, usr_done, ready;
  logic [3:0] nib;
  logic [7:0] cmd;
  logic       usr_req = 1'b1;
  logic [7:0] usr_data = 8'hAA;
  logic       usr_rs = 1'b1;

  lcd_init_seq #(.LINES(2), .BIG_FONT(1), .PWR_WAIT_CYC(T_PWR),
                 .LONG_WAIT_CYC(T_LONG), .SHORT_WAIT_CYC(T_SHORT)) i_lcd_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .nib_req_o(nib_req), .nib_o(nib), .nib_done_i(nib_done),
    .cmd_req_o(cmd_req), .cmd_o(cmd), .cmd_rs_o(cmd_rs), .cmd_done_i(cmd_done),
    .usr_req_i(usr_req), .usr_data_i(usr_data), .usr_rs_i(usr_rs),
    .usr_done_o(usr_done), .ready_o(ready));

  lcd_engine_model #(.DLY(2)) i_mdl_a (
    .clk_i(clk), .nib_req_i(nib_req), .nib_i(nib), .nib_done_o(nib_done),
    .cmd_req_i(cmd_req), .cmd_i(cmd), .cmd_rs_i(cmd_rs), .cmd_done_o(cmd_done));

  logic       nib_req_b, nib_done_b, cmd_req_b, cmd_rs_b, cmd_done_b, usr_done_b, ready_b;
  logic [3:0] nib_b;
  logic [7:0] cmd_b;

  lcd_init_seq #(.LINES(1), .BIG_FONT(0), .PWR_WAIT_CYC(10),
                 .LONG_WAIT_CYC(5), .SHORT_WAIT_CYC(3)) i_lcd_init_seq_b (
    .clk_i(clk), .rst_ni(rst_n), .nib_req_o(nib_req_b), .nib_o(nib_b), .nib_done_i(nib_done_b),
    .cmd_req_o(cmd_req_b), .cmd_o(cmd_b), .cmd_rs_o(cmd_rs_b), .cmd_done_i(cmd_done_b),
    .usr_req_i(1'b0), .usr_data_i(8'h00), .usr_rs_i(1'b0),
    .usr_done_o(usr_done_b), .ready_o(ready_b));

  lcd_engine_model #(.DLY(1)) i_mdl_b (
    .clk_i(clk), .nib_req_i(nib_req_b), .nib_i(nib_b), .nib_done_o(nib_done_b),
    .cmd_req_i(cmd_req_b), .cmd_i(cmd_b), .cmd_rs_i(cmd_rs_b), .cmd_done_o(cmd_done_b));

  logic       nib_req_c, nib_done_c, cmd_req_c, cmd_rs_c, cmd_done_c, usr_done_c, ready_c;
  logic [3:0] nib_c;
  logic [7:0] cmd_c;

  lcd_init_seq #(.LINES(3), .BIG_FONT(0), .PWR_WAIT_CYC(10),
                 .LONG_WAIT_CYC(5), .SHORT_WAIT_CYC(3)) i_lcd_init_seq_c (
    .clk_i(clk), .rst_ni(rst_n), .nib_req_o(nib_req_c), .nib_o(nib_c), .nib_done_i(nib_done_c),
    .cmd_req_o(cmd_req_c), .cmd_o(cmd_c), .cmd_rs_o(cmd_rs_c), .cmd_done_i(cmd_done_c),
    .usr_req_i(1'b1), .usr_data_i(8'h55), .usr_rs_i(1'b1),
    .usr_done_o(usr_done_c), .ready_o(ready_c));

  lcd_engine_model #(.DLY(1)) i_mdl_c (
    .clk_i(clk), .nib_req_i(nib_req_c), .nib_i(nib_c), .nib_done_o(nib_done_c),
    .cmd_req_i(cmd_req_c), .cmd_i(cmd_c), .cmd_rs_i(cmd_rs_c), .cmd_done_o(cmd_done_c));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check(nib_req == 1'b0 && cmd_req == 1'b0, "R1 requests in reset", {nib_req, cmd_req}, 0);
    check(nib == 4'h0, "R1 nibble in reset", nib, 0);
    check(usr_done == 1'b0, "R10 usr_done in reset", usr_done, 0);
  endtask

  task automatic t_power_wait();
    int errs = 0;
    rel = i_mdl_a.cyc;
    rst_n = 1'b1;
    for (int i = 0; i < T_PWR - 5; i++) begin
      @(negedge clk);
      if (nib_req || cmd_req || ready || usr_done || nib != 4'h0) errs++;
    end
    check(errs == 0, "R1 R10 idle during power wait", errs, 0);
  endtask

  task automatic t_wait_ready();
    int k = 0;
    while (!(cmd_done && cmd == 8'h01 && !ready) && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check(k < 5000, "R9 clear command completes", k, 0);
    check(ready == 1'b0, "R9 ready low in clear done cycle", ready, 0);
    @(negedge clk);
    check(ready == 1'b1, "R9 ready high one cycle after clear done", ready, 1);
  endtask

  task automatic t_user_pass();
    int k = 0;
    while (!usr_done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(usr_done == 1'b1, "R10 user request completes after ready", usr_done, 1);
    usr_req = 1'b0;
    repeat (10) @(negedge clk);
    check(ready == 1'b1, "R9 ready stays high", ready, 1);
  endtask

  task automatic t_log_a();
    check(i_mdl_a.n == 8, "R10 entry count (7 init + 1 user)", i_mdl_a.n, 8);
    if (i_mdl_a.n != 8) return;
    check(i_mdl_a.st_l[0] - rel >= T_PWR && i_mdl_a.st_l[0] - rel <= T_PWR + 4,
          "R1 power-up gap", i_mdl_a.st_l[0] - rel, T_PWR);
    for (int i = 0; i < 3; i++)
      check(i_mdl_a.kind_l[i] == 1'b0 && i_mdl_a.val_l[i] == 8'h03,
            (i == 0) ? "R2 first nibble" : "R3 wake nibble", i_mdl_a.val_l[i], 3);
    check(i_mdl_a.kind_l[3] == 1'b0 && i_mdl_a.val_l[3] == 8'h02, "R4 fourth nibble",
          i_mdl_a.val_l[3], 2);
    check(i_mdl_a.st_l[1] - i_mdl_a.dn_l[0] >= T_LONG && i_mdl_a.st_l[1] - i_mdl_a.dn_l[0] <= T_LONG + 4,
          "R2 long gap", i_mdl_a.st_l[1] - i_mdl_a.dn_l[0], T_LONG);
    check(i_mdl_a.st_l[2] - i_mdl_a.dn_l[1] >= T_SHORT && i_mdl_a.st_l[2] - i_mdl_a.dn_l[1] <= T_SHORT + 4,
          "R3 short gap", i_mdl_a.st_l[2] - i_mdl_a.dn_l[1], T_SHORT);
    check(i_mdl_a.st_l[3] - i_mdl_a.dn_l[2] <= 3, "R4 no wait before 4-bit nibble",
          i_mdl_a.st_l[3] - i_mdl_a.dn_l[2], 3);
    check(i_mdl_a.kind_l[4] && i_mdl_a.st_l[4] > i_mdl_a.dn_l[3], "R4 command after nibble done",
          i_mdl_a.st_l[4], i_mdl_a.dn_l[3] + 1);
    check(i_mdl_a.kind_l[4] && i_mdl_a.val_l[4] == 8'h2C && !i_mdl_a.rs_l[4],
          "R5 function set two lines big font", i_mdl_a.val_l[4], 8'h2C);
    check(i_mdl_a.kind_l[5] && i_mdl_a.val_l[5] == 8'h0C && !i_mdl_a.rs_l[5] &&
          i_mdl_a.st_l[5] > i_mdl_a.dn_l[4], "R6 display on", i_mdl_a.val_l[5], 8'h0C);
    check(i_mdl_a.kind_l[6] && i_mdl_a.val_l[6] == 8'h01 && !i_mdl_a.rs_l[6] &&
          i_mdl_a.st_l[6] > i_mdl_a.dn_l[5], "R6 clear", i_mdl_a.val_l[6], 8'h01);
    check(i_mdl_a.kind_l[7] && i_mdl_a.val_l[7] == 8'hAA && i_mdl_a.rs_l[7] &&
          i_mdl_a.st_l[7] > i_mdl_a.dn_l[6], "R10 user byte passed after ready",
          i_mdl_a.val_l[7], 8'hAA);
    check(i_mdl_a.viol == 0, "R7 R8 handshake stable and ports exclusive", i_mdl_a.viol, 0);
  endtask

  task automatic t_one_line();
    check(i_mdl_b.n == 7, "R5 one-line entry count", i_mdl_b.n, 7);
    check(i_mdl_b.kind_l[4] && i_mdl_b.val_l[4] == 8'h20, "R5 function set one line small font",
          i_mdl_b.val_l[4], 8'h20);
    check(ready_b == 1'b1, "R9 one-line ready", ready_b, 1);
    check(i_mdl_b.viol == 0, "R8 one-line ports exclusive", i_mdl_b.viol, 0);
  endtask

  task automatic t_bad_lines();
    check(i_mdl_c.n == 0, "R11 no requests with illegal line count", i_mdl_c.n, 0);
    check(ready_c == 1'b0 && usr_done_c == 1'b0, "R11 never ready", ready_c, 0);
  endtask

  initial begin
    #(4 * 50000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_wait();
    t_wait_ready();
    t_user_pass();
    t_log_a();
    t_one_line();
    t_bad_lines();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule